// File: doc/BRIEF.md
# Grayscale PWM Column Output Engine

This block turns one display row of 10-bit grayscale words into on/off drive for a bank of LED column channels (48 by default) during a single row scan. A one-cycle scan-start strobe captures the row's words into holding registers and launches a scan timed on the reference clock: a dark blanking interval of 63 cycles, then two back-to-back PWM windows of 1023 cycles each. In each window, a channel stays on for as many cycles as its grayscale value.

A brightness input decides whether the second window drives the columns. Its two low bits belong to an analog current setting outside this block: they are accepted and ignored. The channels are interleaved red, green, blue. Each colour has its own active-low output enable that forces the whole group off at once. After the second window the engine stays dark until the next scan-start strobe. A strobe that arrives in the middle of a scan restarts the scan from the blanking interval.

Top module: `colpwm_engine`

## Requirements
- R1: While reset is asserted, and after reset until the first scan-start strobe, every bit of colOn is 0.
- R2: For the 63 cycles after the clock edge that samples scanStart high, every bit of colOn is 0 (blanking interval).
- R3: The blanking interval is followed by a first and then a second PWM window of 1023 cycles each, so a scan lasts 2109 cycles; after it, all outputs stay 0 until the next scanStart.
- R4: Within a window, the channel with grayscale value N (0 to 1023) is on for the first N cycles and off for the rest: value 0 never turns on, and value 1023 is on for the whole window.
- R5: With brd[2]=1 both windows drive the outputs; with brd[2]=0 the second window is forced off and the first window is unaffected.
- R6: colOn bit i drives channel i+1, and grayRow bits [10*i+9:10*i] hold its word; bits with i mod 3 = 0 are red, i mod 3 = 1 green, i mod 3 = 2 blue.
- R7: While oebRed, oebGreen or oebBlue is 1, every output of that colour group is 0, whatever the PWM state; the enables act in the same cycle.
- R8: brd[1:0] has no effect on colOn.
- R9: grayRow is sampled only on the edge where scanStart is 1; changes to grayRow during a scan do not alter that scan's outputs.
- R10: A scanStart during a scan restarts the scan with a new blanking interval and newly sampled words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | PWM reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| scanStart | input | 1 | One-cycle pulse that samples grayRow and begins a scan |
| grayRow | input | 480 | 48 grayscale words, channel i in bits [10*i+9:10*i] |
| brd | input | 3 | Brightness: bit 2 enables the second window, bits 1:0 unused here |
| oebRed | input | 1 | Active-low enable for red channels |
| oebGreen | input | 1 | Active-low enable for green channels |
| oebBlue | input | 1 | Active-low enable for blue channels |
| colOn | output | 48 | Column drive, 1 = channel on |

## Verification
The embedded properties watch every cycle for the structural rules: no output outside a window, the second window dark while brd[2] is low, a red output never on with its enable high, the window counter stepping by one and handing over between windows, a restart on every strobe, and held words that change only on a strobe. Only the bench scenarios show the exact on-time per grayscale value at the 0, 1, 1022 and 1023 boundaries. The same holds for the colour interleave seen at the pins, for enable toggles in mid-scan, for the lack of effect of brd[1:0] and of mid-scan grayRow updates, and for the scan length measured from the strobe.

// File: rtl/colpwm_pkg.sv
package colpwm_pkg;
  localparam int GRAY_W  = 10;
  localparam int WIN_CYC = (1 << GRAY_W) - 1;

  typedef logic [GRAY_W-1:0] gray_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic  load;       // capture grayscale words this edge
    logic  winActive;  // inside either PWM window
    logic  secondWin;  // inside the second PWM window
    gray_t winCnt;     // cycle index within the current window
  } pwm_strobe_t;
endpackage

// File: rtl/colpwm_ctrl.sv
module colpwm_ctrl
  import colpwm_pkg::*;
#(
  parameter int MASK_CYC = 63
) (
  input  logic        refClk,
  input  logic        rstN,
  input  logic        scanStart,
  output pwm_strobe_t strobe
);
  localparam int MASK_W = $clog2(MASK_CYC + 1);
  localparam logic [MASK_W-1:0] MASK_LAST = MASK_W'(MASK_CYC - 1);
  localparam gray_t WIN_LAST = gray_t'(WIN_CYC - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_MASK, PH_WIN1, PH_WIN2} phase_t;

  phase_t            phase;
  logic [MASK_W-1:0] maskCnt;
  gray_t             winCnt;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      maskCnt <= '0;
      winCnt  <= '0;
    end else if (scanStart) begin
      phase   <= PH_MASK;
      maskCnt <= '0;
      winCnt  <= '0;
    end else begin
      unique case (phase)
        PH_MASK: begin
          if (maskCnt == MASK_LAST) begin
            phase  <= PH_WIN1;
            winCnt <= '0;
          end else begin
            maskCnt <= maskCnt + 1'b1;
          end
        end
        PH_WIN1: begin
          if (winCnt == WIN_LAST) begin
            phase  <= PH_WIN2;
            winCnt <= '0;
          end else begin
            winCnt <= winCnt + 1'b1;
          end
        end
        PH_WIN2: begin
          if (winCnt == WIN_LAST) begin
            phase  <= PH_IDLE;
            winCnt <= '0;
          end else begin
            winCnt <= winCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.load      = scanStart;
    strobe.winActive = (phase == PH_WIN1) || (phase == PH_WIN2);
    strobe.secondWin = (phase == PH_WIN2);
    strobe.winCnt    = winCnt;
  end

  // R10: every strobe restarts at the start of blanking
  p_restart_r10: assert property (@(posedge refClk) disable iff (!rstN)
    scanStart |=> (phase == PH_MASK) && (maskCnt == '0));

  // R2: blanking lasts exactly MASK_CYC cycles before the first window
  p_mask_exit_r2: assert property (@(posedge refClk) disable iff (!rstN)
    (phase == PH_MASK) && (maskCnt == MASK_LAST) && !scanStart
      |=> (phase == PH_WIN1) && (winCnt == '0));

  // R3: the window counter advances by one inside a window
  p_win_step_r3: assert property (@(posedge refClk) disable iff (!rstN)
    strobe.winActive && (winCnt != WIN_LAST) && !scanStart
      |=> strobe.winActive && (winCnt == $past(winCnt) + 1'b1));

  // R3: the first window hands over to the second
  p_win_handoff_r3: assert property (@(posedge refClk) disable iff (!rstN)
    (phase == PH_WIN1) && (winCnt == WIN_LAST) && !scanStart
      |=> strobe.secondWin && (winCnt == '0));
endmodule

// File: rtl/colpwm_datapath.sv
module colpwm_datapath
  import colpwm_pkg::*;
#(
  parameter int NUM_CH = 48
) (
  input  logic                     refClk,
  input  logic                     rstN,
  input  pwm_strobe_t              strobe,
  input  logic [NUM_CH*GRAY_W-1:0] grayRow,
  input  logic                     secondWinEn,
  input  logic                     oebRed,
  input  logic                     oebGreen,
  input  logic                     oebBlue,
  output logic [NUM_CH-1:0]        colOn
);
  gray_t       heldGray [NUM_CH];
  logic [NUM_CH-1:0] rawOn;
  logic [2:0]  oebVec;
  logic        winGate;

  assign oebVec  = {oebBlue, oebGreen, oebRed};
  assign winGate = strobe.winActive && (!strobe.secondWin || secondWinEn);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge refClk or negedge rstN) begin
      if (!rstN)            heldGray[i] <= '0;
      else if (strobe.load) heldGray[i] <= grayRow[i*GRAY_W +: GRAY_W];
    end

    assign rawOn[i] = winGate && (strobe.winCnt < heldGray[i]);
    assign colOn[i] = rawOn[i] & ~oebVec[i % 3];

    // R9: held words change only on a scan-start strobe
    p_hold_r9: assert property (@(posedge refClk) disable iff (!rstN)
      !strobe.load |=> $stable(heldGray[i]));

    if (i % 3 == 0) begin : g_red
      // R7: disabled red channel is never on
      p_red_off_r7: assert property (@(posedge refClk) disable iff (!rstN)
        oebRed |-> !colOn[i]);
    end
  end

  // R2: nothing is on outside a PWM window
  p_dark_outside_r2: assert property (@(posedge refClk) disable iff (!rstN)
    !strobe.winActive |-> (colOn == '0));

  // R5: second window is dark when it is not enabled
  p_second_off_r5: assert property (@(posedge refClk) disable iff (!rstN)
    strobe.secondWin && !secondWinEn |-> (colOn == '0));
endmodule

// File: rtl/colpwm_engine.sv
module colpwm_engine
  import colpwm_pkg::*;
#(
  parameter int NUM_CH   = 48,
  parameter int MASK_CYC = 63
) (
  input  logic                     refClk,
  input  logic                     rstN,
  input  logic                     scanStart,
  input  logic [NUM_CH*GRAY_W-1:0] grayRow,
  input  logic [2:0]               brd,
  input  logic                     oebRed,
  input  logic                     oebGreen,
  input  logic                     oebBlue,
  output logic [NUM_CH-1:0]        colOn
);
  pwm_strobe_t strobe;
  logic        unusedCurrentBits;

  // brd[1:0] set analog current elsewhere; no timing effect here
  assign unusedCurrentBits = ^brd[1:0];

  colpwm_ctrl #(.MASK_CYC(MASK_CYC)) u_ctrl (
    .refClk    (refClk),
    .rstN      (rstN),
    .scanStart (scanStart),
    .strobe    (strobe)
  );

  colpwm_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .refClk      (refClk),
    .rstN        (rstN),
    .strobe      (strobe),
    .grayRow     (grayRow),
    .secondWinEn (brd[2]),
    .oebRed      (oebRed),
    .oebGreen    (oebGreen),
    .oebBlue     (oebBlue),
    .colOn       (colOn)
  );

  // R1: outputs dark while held in reset
  always_comb begin
    if (!rstN) a_reset_dark_r1: assert (colOn == '0);
  end
endmodule

// File: tb/colpwm_engine_tb.sv
module colpwm_engine_tb;
  localparam int NCH  = 48;
  localparam int GW   = 10;
  localparam int MASK = 63;
  localparam int WIN  = 1023;
  localparam int SCAN = MASK + 2*WIN;

  logic              refClk = 0;
  logic              rstN = 0;
  logic              scanStart = 0;
  logic [NCH*GW-1:0] grayRow = '0;
  logic [2:0]        brd = 3'b100;
  logic              oebRed = 0, oebGreen = 0, oebBlue = 0;
  logic [NCH-1:0]    colOn;

  int checks = 0;
  int errors = 0;
  int curVal [NCH];
  int capVal [NCH];

  colpwm_engine u_dut (
    .refClk(refClk), .rstN(rstN), .scanStart(scanStart), .grayRow(grayRow),
    .brd(brd), .oebRed(oebRed), .oebGreen(oebGreen), .oebBlue(oebBlue),
    .colOn(colOn)
  );

  always #4 refClk = ~refClk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic setPattern(input int kind);
    for (int i = 0; i < NCH; i++) begin
      case (kind)
        0: curVal[i] = 0;
        1: curVal[i] = 1023;
        2: curVal[i] = (i * 97 + 3) % 1024;
        3: curVal[i] = (i % 4 == 0) ? 0 : (i % 4 == 1) ? 1023 : (i % 4 == 2) ? 1 : 1022;
        default: curVal[i] = (i * 211 + 500) % 1024;
      endcase
      grayRow[i*GW +: GW] = GW'(curVal[i]);
    end
  endtask

  function automatic logic [NCH-1:0] expVec(input int k);
    logic [NCH-1:0] v;
    int pos;
    bit inWin;
    v = '0;
    inWin = 0;
    pos = 0;
    if (k >= MASK && k < MASK + WIN) begin inWin = 1; pos = k - MASK; end
    else if (k >= MASK + WIN && k < SCAN && brd[2]) begin inWin = 1; pos = k - MASK - WIN; end
    for (int i = 0; i < NCH; i++) begin
      bit gateOff;
      gateOff = (i % 3 == 0) ? oebRed : (i % 3 == 1) ? oebGreen : oebBlue;
      v[i] = inWin && (pos < capVal[i]) && !gateOff;
    end
    return v;
  endfunction

  // evKind: 1 new grayRow, 2 green enable off, 3 flip brd[1:0], 4 red enable off
  task automatic runScan(input string req, input int stopAt, input int evK, input int evKind);
    int bad [4];
    int firstK [4];
    logic [NCH-1:0] fa [4];
    logic [NCH-1:0] fe [4];
    bit reached [4];
    for (int r = 0; r < 4; r++) begin bad[r] = 0; reached[r] = 0; firstK[r] = -1; end
    @(negedge refClk);
    for (int i = 0; i < NCH; i++) capVal[i] = curVal[i];
    scanStart = 1;
    for (int k = 0; k <= stopAt && k <= SCAN + 3; k++) begin
      int r;
      logic [NCH-1:0] e;
      @(negedge refClk);
      scanStart = 0;
      if (k == evK) begin
        case (evKind)
          1: setPattern(4);
          2: oebGreen = 1;
          3: brd[1:0] = ~brd[1:0];
          4: oebRed = 1;
          default: ;
        endcase
      end
      #1;
      r = (k < MASK) ? 0 : (k < MASK + WIN) ? 1 : (k < SCAN) ? 2 : 3;
      reached[r] = 1;
      e = expVec(k);
      if (colOn !== e) begin
        if (bad[r] == 0) begin firstK[r] = k; fa[r] = colOn; fe[r] = e; end
        bad[r]++;
      end
    end
    for (int r = 0; r < 4; r++) begin
      if (reached[r])
        check(bad[r] == 0, req,
              $sformatf("region %0d: %0d bad cycles, first at k=%0d", r, bad[r], firstK[r]),
              fa[r], fe[r]);
    end
  endtask

  task automatic testReset();
    setPattern(1);
    brd = 3'b111;
    repeat (3) @(negedge refClk);
    check(colOn == '0, "R1", "dark in reset", colOn, '0);
    rstN = 1;
    for (int n = 0; n < 20; n++) begin
      @(negedge refClk);
      if (n == 19) check(colOn == '0, "R1", "dark after reset before scan", colOn, '0);
    end
  endtask

  task automatic testRamp();
    brd = 3'b100;
    setPattern(2);
    runScan("R2 R3 R4 R6", SCAN + 3, -1, 0);
  endtask

  task automatic testBounds();
    setPattern(3);
    runScan("R4", SCAN + 3, -1, 0);
    setPattern(1);
    runScan("R4 full", SCAN + 3, -1, 0);
    setPattern(0);
    runScan("R4 zero", SCAN + 3, -1, 0);
  endtask

  task automatic testSecondWindow();
    brd = 3'b000;
    setPattern(1);
    runScan("R5", SCAN + 3, -1, 0);
    brd = 3'b100;
  endtask

  task automatic testEnables();
    setPattern(1);
    oebBlue = 1;
    runScan("R6 R7", SCAN + 3, MASK + 300, 2);
    oebBlue = 0; oebGreen = 0;
    runScan("R7 mid-window red", SCAN + 3, MASK + WIN + 10, 4);
    oebRed = 0;
  endtask

  task automatic testCurrentBits();
    brd = 3'b101;
    setPattern(2);
    runScan("R8", SCAN + 3, MASK + 200, 3);
    brd = 3'b100;
  endtask

  task automatic testLateUpdate();
    setPattern(3);
    runScan("R9", SCAN + 3, MASK + 5, 1);
  endtask

  task automatic testRestart();
    setPattern(1);
    runScan("R10 partial", MASK + 400, -1, 0);
    setPattern(2);
    runScan("R10 restarted", SCAN + 3, -1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge refClk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testRamp();
    testBounds();
    testSecondWindow();
    testEnables();
    testCurrentBits();
    testLateUpdate();
    testRestart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule